// File: doc/BRIEF.md
# Barrel Shifter With Carry-Out

This block moves a 32-bit operand left or right in a single combinational pass and registers the outcome. It supports four kinds of shift: logical left, logical right, arithmetic right and rotate right. Alongside the shifted word it produces a sign indication (N), a zero indication (Z) and an updated carry.

The shift distance is eight bits wide. It comes either from a 6-bit immediate field or from the least significant byte of a 32-bit register value. Distances beyond the operand width can therefore occur, and each shift kind handles them by a fixed rule. A datapath presents a request with `in_valid`. One clock later the registered result appears with `out_valid`, and `flags_we` tells the consumer whether to commit the flags.

The output stage is a two-state machine. State `ST_EMPTY` means no result is held. State `ST_FULL` means a result captured on the previous edge is on the outputs. Its transitions are:

- `EMPTY->FULL` when `in_valid` is high.
- `FULL->FULL` on a back-to-back request.
- `FULL->EMPTY` when `in_valid` is low.
- Reset returns the machine to `ST_EMPTY`.

Top module: `bsh_unit`

## Requirements
- R1: Kind 0 (logical left) by a distance d in 1..31 fills vacated low bits with zeros. C becomes operand bit 32-d, the last bit pushed out at the top.
- R2: Kind 1 (logical right) by d in 1..31 fills vacated high bits with zeros. C becomes operand bit d-1.
- R3: Kind 2 (arithmetic right) by d in 1..31 copies bit 31 into the vacated high bits and sets C to operand bit d-1. For d of 32 or more, every result bit equals bit 31 and C equals bit 31.
- R4: Kind 3 (rotate right) re-enters the bits that leave at the bottom at the top, using d modulo 32. When d is a nonzero multiple of 32, the result equals the operand and C equals bit 31. Otherwise C is bit (d mod 32)-1.
- R5: With `amt_from_reg`=1 the distance is `amt_reg[7:0]`, and bits 31:8 have no effect. With `amt_from_reg`=0 the distance is `amt_imm` (0..63).
- R6: A distance of zero returns the operand unchanged and passes `carry_in` to C, for every kind.
- R7: A logical shift by exactly 32 gives a zero result, with C equal to bit 0 (left) or bit 31 (right). A logical shift by 33 or more gives a zero result and C=0.
- R8: N equals result bit 31 and Z is 1 exactly when the result is zero.
- R9: With `set_flags`=0, `flags_we` is 0 and C equals `carry_in`. With `set_flags`=1, `flags_we` is 1 and C follows R1-R7.
- R10: Outputs are registered: a request accepted on an edge shows on the outputs after that edge with `out_valid`=1. A cycle with `in_valid`=0 clears `out_valid` and `flags_we` while result and flags hold. After reset, `out_valid`, `flags_we` and result are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| operand | input | 32 | Value to shift |
| shift_kind | input | 2 | 0 left logical, 1 right logical, 2 right arithmetic, 3 rotate right |
| amt_from_reg | input | 1 | 1 selects register distance, 0 selects immediate |
| amt_imm | input | 6 | Immediate distance |
| amt_reg | input | 32 | Register whose low byte gives the distance |
| carry_in | input | 1 | Current carry flag |
| set_flags | input | 1 | Request that flags be updated |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Shifted value |
| flag_n | output | 1 | Result bit 31 |
| flag_z | output | 1 | Result is zero |
| flag_c | output | 1 | Updated carry |
| flags_we | output | 1 | Flags should be committed |

## Verification
Each shift kind is driven with patterns whose top and bottom bits differ. This includes a negative operand with a set bit 0, which makes zero-fill, sign-fill and wrap-around give distinct words, and a carry that tells bit d-1 apart from its neighbours. Distances 0, 1, 31, 32, 33, 64 and 255 separate the in-range path from the saturating and modulo rules. They also show whether C is held, taken from an edge bit, or cleared. Register distances with nonzero upper bits expose any use of more than the low byte. Runs with `set_flags` low, and idle cycles after a request, distinguish carry pass-through and output holding from fresh updates.

// File: rtl/bsh_pkg.sv
package bsh_pkg;
    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_st_e;
endpackage

// File: rtl/bsh_amount.sv
module bsh_amount #(
    parameter int W    = 32,
    parameter int IMMW = 6,
    parameter int AW   = 8
) (
    input  logic            from_reg,
    input  logic [IMMW-1:0] imm,
    input  logic [W-1:0]    regv,
    output logic [AW-1:0]   amt
);
    // Only the low byte of the register source is significant.
    always_comb begin
        if (from_reg) amt = regv[AW-1:0];
        else          amt = AW'(imm);
    end
endmodule

// File: rtl/bsh_core.sv
module bsh_core
    import bsh_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 8
) (
    input  logic [W-1:0]  x,
    input  logic [1:0]    kind,
    input  logic [AW-1:0] amt,
    input  logic          cin,
    output logic [W-1:0]  res,
    output logic          cout
);
    localparam int LW = $clog2(W);
    localparam logic [AW-1:0] WA = AW'(W);

    logic [LW-1:0] lo, neg, dn;
    logic          big, exact, zero;
    shift_kind_e   k;

    always_comb begin
        k     = shift_kind_e'(kind);
        lo    = amt[LW-1:0];
        neg   = LW'(0) - lo;
        dn    = lo - LW'(1);
        big   = (amt >= WA);
        exact = (amt == WA);
        zero  = (amt == '0);
        res   = x;
        cout  = cin;
        if (!zero) begin
            unique case (k)
                SK_LSL: begin
                    if (big) begin
                        res  = '0;
                        cout = exact ? x[0] : 1'b0;
                    end else begin
                        res  = x << lo;
                        cout = x[neg];
                    end
                end
                SK_LSR: begin
                    if (big) begin
                        res  = '0;
                        cout = exact ? x[W-1] : 1'b0;
                    end else begin
                        res  = x >> lo;
                        cout = x[dn];
                    end
                end
                SK_ASR: begin
                    if (big) begin
                        res  = {W{x[W-1]}};
                        cout = x[W-1];
                    end else begin
                        res  = $unsigned($signed(x) >>> lo);
                        cout = x[dn];
                    end
                end
                SK_ROR: begin
                    if (lo == '0) begin
                        res  = x;
                        cout = x[W-1];
                    end else begin
                        res  = (x >> lo) | (x << neg);
                        cout = x[dn];
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bsh_unit.sv
module bsh_unit
    import bsh_pkg::*;
#(
    parameter int W    = 32,
    parameter int IMMW = 6,
    parameter int AW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [W-1:0]    operand,
    input  logic [1:0]      shift_kind,
    input  logic            amt_from_reg,
    input  logic [IMMW-1:0] amt_imm,
    input  logic [W-1:0]    amt_reg,
    input  logic            carry_in,
    input  logic            set_flags,
    output logic            out_valid,
    output logic [W-1:0]    result,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_c,
    output logic            flags_we
);
    localparam logic [AW-1:0] WA = AW'(W);

    logic [AW-1:0] amt;
    logic [W-1:0]  sh_res;
    logic          sh_c;
    stage_st_e     st_q, st_d;

    bsh_amount #(.W(W), .IMMW(IMMW), .AW(AW)) u_amt (
        .from_reg (amt_from_reg),
        .imm      (amt_imm),
        .regv     (amt_reg),
        .amt      (amt)
    );

    bsh_core #(.W(W), .AW(AW)) u_core (
        .x    (operand),
        .kind (shift_kind),
        .amt  (amt),
        .cin  (carry_in),
        .res  (sh_res),
        .cout (sh_c)
    );

    // Output stage state machine.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: if (in_valid)  st_d = ST_FULL;
            ST_FULL:  if (!in_valid) st_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result   <= '0;
            flag_n   <= 1'b0;
            flag_z   <= 1'b0;
            flag_c   <= 1'b0;
            flags_we <= 1'b0;
        end else if (in_valid) begin
            result   <= sh_res;
            flag_n   <= sh_res[W-1];
            flag_z   <= (sh_res == '0);
            flag_c   <= set_flags ? sh_c : carry_in;
            flags_we <= set_flags;
        end else begin
            flags_we <= 1'b0;
        end
    end

    assign out_valid = (st_q == ST_FULL);

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r10_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !flags_we && $stable(result)));
    a_r6_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && amt == '0) |=> (result == $past(operand) && flag_c == $past(carry_in)));
    a_r7_logical_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && set_flags && amt > WA && !shift_kind[1]) |=> (result == '0 && !flag_c));
    a_r3_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && shift_kind == 2'd2 && amt >= WA) |=> (result == '0 || result == '1));
    a_r8_nz_match: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == (result == '0) && flag_n == result[W-1]));
    a_r9_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !set_flags) |=> (!flags_we && flag_c == $past(carry_in)));
    a_r9_we_valid: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> out_valid);
endmodule

// File: tb/sim_bsh_unit.sv
module sim_bsh_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  shift_kind = '0;
    logic        amt_from_reg = 1'b0;
    logic [5:0]  amt_imm = '0;
    logic [31:0] amt_reg = '0;
    logic        carry_in = 1'b0;
    logic        set_flags = 1'b0;
    logic        out_valid, flag_n, flag_z, flag_c, flags_we;
    logic [31:0] result;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bsh_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
        .shift_kind(shift_kind), .amt_from_reg(amt_from_reg), .amt_imm(amt_imm),
        .amt_reg(amt_reg), .carry_in(carry_in), .set_flags(set_flags),
        .out_valid(out_valid), .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flags_we(flags_we)
    );

    task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // One-bit-per-step reference model.
    task automatic model(input logic [1:0] kind, input int d, input logic [31:0] x, input logic ci,
                         output logic [31:0] r, output logic c);
        r = x;
        c = ci;
        for (int i = 0; i < d; i++) begin
            case (kind)
                2'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
                2'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
                2'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
                default: begin c = r[0]; r = {r[0], r[31:1]}; end
            endcase
        end
    endtask

    task automatic run(input string req, input logic [1:0] kind, input logic from_reg,
                       input logic [5:0] imm, input logic [31:0] rv, input logic [31:0] x,
                       input logic ci, input logic sf);
        logic [31:0] er;
        logic        ec;
        int          d;
        d = from_reg ? int'(rv[7:0]) : int'(imm);
        model(kind, d, x, ci, er, ec);
        if (!sf) ec = ci;
        @(negedge clk);
        in_valid = 1'b1; shift_kind = kind; amt_from_reg = from_reg; amt_imm = imm;
        amt_reg = rv; operand = x; carry_in = ci; set_flags = sf;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "result", result, er);
        check(req, "C", {31'b0, flag_c}, {31'b0, ec});
        check("R8", "N", {31'b0, flag_n}, {31'b0, er[31]});
        check("R8", "Z", {31'b0, flag_z}, {31'b0, er == 32'h0});
        check("R10", "out_valid", {31'b0, out_valid}, 32'h1);
        check("R9", "flags_we", {31'b0, flags_we}, {31'b0, sf});
    endtask

    task automatic t_reset();
        check("R10", "reset out_valid", {31'b0, out_valid}, 32'h0);
        check("R10", "reset result", result, 32'h0);
        check("R10", "reset flags_we", {31'b0, flags_we}, 32'h0);
    endtask

    task automatic t_lsl();   // R1
        run("R1", 2'd0, 1'b0, 6'd1, 32'h0, 32'h2375A2B4, 1'b0, 1'b1);
        run("R1", 2'd0, 1'b0, 6'd4, 32'h0, 32'h8F00000F, 1'b0, 1'b1);
        run("R1", 2'd0, 1'b0, 6'd31, 32'h0, 32'h00000003, 1'b1, 1'b1);
    endtask

    task automatic t_lsr();   // R2
        run("R2", 2'd1, 1'b0, 6'd1, 32'h0, 32'h8375A2B7, 1'b0, 1'b1);
        run("R2", 2'd1, 1'b0, 6'd2, 32'h0, 32'h8375A2B7, 1'b1, 1'b1);
        run("R2", 2'd1, 1'b0, 6'd31, 32'h0, 32'h80000001, 1'b0, 1'b1);
    endtask

    task automatic t_asr();   // R3
        run("R3", 2'd2, 1'b0, 6'd1, 32'h0, 32'h8375A2B7, 1'b0, 1'b1);
        run("R3", 2'd2, 1'b0, 6'd8, 32'h0, 32'h7F00FF80, 1'b1, 1'b1);
        run("R3", 2'd2, 1'b0, 6'd32, 32'h0, 32'h80000000, 1'b0, 1'b1);
        run("R3", 2'd2, 1'b1, 6'd0, 32'h000000C8, 32'h40000001, 1'b1, 1'b1);
    endtask

    task automatic t_ror();   // R4
        run("R4", 2'd3, 1'b0, 6'd1, 32'h0, 32'h8375A2B7, 1'b0, 1'b1);
        run("R4", 2'd3, 1'b0, 6'd36, 32'h0, 32'h1234567E, 1'b0, 1'b1);
        run("R4", 2'd3, 1'b0, 6'd32, 32'h0, 32'h80000010, 1'b0, 1'b1);
        run("R4", 2'd3, 1'b1, 6'd0, 32'h00000040, 32'h00000011, 1'b1, 1'b1);
    endtask

    task automatic t_src();   // R5
        run("R5", 2'd1, 1'b1, 6'd3, 32'hFFFFFF04, 32'hF0F0F0F8, 1'b0, 1'b1);
        run("R5", 2'd0, 1'b1, 6'd0, 32'hABCDEF00, 32'h12345678, 1'b1, 1'b1);
        run("R5", 2'd0, 1'b0, 6'd63, 32'h00000001, 32'hFFFFFFFF, 1'b1, 1'b1);
    endtask

    task automatic t_zero();  // R6
        run("R6", 2'd0, 1'b0, 6'd0, 32'h0, 32'hDEADBEEF, 1'b1, 1'b1);
        run("R6", 2'd3, 1'b0, 6'd0, 32'h0, 32'h80000000, 1'b0, 1'b1);
        run("R6", 2'd2, 1'b1, 6'd5, 32'h00000100, 32'h00000000, 1'b1, 1'b1);
    endtask

    task automatic t_edge();  // R7
        run("R7", 2'd0, 1'b0, 6'd32, 32'h0, 32'h00000001, 1'b0, 1'b1);
        run("R7", 2'd1, 1'b0, 6'd32, 32'h0, 32'h80000000, 1'b0, 1'b1);
        run("R7", 2'd0, 1'b0, 6'd33, 32'h0, 32'hFFFFFFFF, 1'b1, 1'b1);
        run("R7", 2'd1, 1'b1, 6'd0, 32'h000000FF, 32'hFFFFFFFF, 1'b1, 1'b1);
    endtask

    task automatic t_noflags(); // R9
        run("R9", 2'd1, 1'b0, 6'd1, 32'h0, 32'h00000001, 1'b0, 1'b0);
        run("R9", 2'd0, 1'b0, 6'd33, 32'h0, 32'h00000001, 1'b1, 1'b0);
    endtask

    task automatic t_hold();  // R10
        logic [31:0] keep;
        run("R10", 2'd1, 1'b0, 6'd4, 32'h0, 32'hA5A5A5A5, 1'b0, 1'b1);
        keep = result;
        @(negedge clk);
        check("R10", "idle out_valid", {31'b0, out_valid}, 32'h0);
        check("R10", "idle flags_we", {31'b0, flags_we}, 32'h0);
        check("R10", "idle result hold", result, keep);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_lsl();
        t_lsr();
        t_asr();
        t_ror();
        t_src();
        t_zero();
        t_edge();
        t_noflags();
        t_hold();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule